// File: doc/BRIEF.md
# Register ID Select and Dual-Write Register File

This block is the operand-read and result-commit slice of a one-instruction-per-cycle processor. From the instruction code, the two register fields of the current instruction and the condition flag produced by execute, it works out which registers the two read ports address and which registers the two write ports target. Read results come out combinationally in the same cycle. The ALU result and the memory result are committed on the next rising clock edge.

The register ID space has sixteen codes. Codes 0 to 14 name 64-bit registers. Code 15 means "no register". A read port given code 15 returns zero, and a write port given code 15 writes nothing. Stack instructions address the stack pointer (ID 4) on their own, without using a register field. A conditional move whose condition fails cancels its write by steering its destination to code 15. All pins are plain control and data with no handshake: the surrounding sequencer presents one instruction per cycle, and both write ports commit on every edge unless their ID is 15.

Top module: `regid_decode_wb`

## Requirements
- R1: For icode 0x6 (ALU operation), src_a = ra, src_b = rb, dst_e = rb and dst_m = 15.
- R2: For icode 0xB (pop), src_a, src_b and dst_e are 4, and dst_m = ra. In one edge, register 4 takes val_e and register ra takes val_m.
- R3: For icode 0x9 (return), src_a = src_b = dst_e = 4 and dst_m = 15. For icode 0x8 (call), src_a = 15, src_b = dst_e = 4 and dst_m = 15.
- R4: For icode 0x2 (conditional move), src_a = ra, src_b = 15 and dst_m = 15. dst_e = rb when cnd is 1 and 15 when cnd is 0, so a failed condition leaves rb unchanged.
- R5: For icode 0x4 (register-to-memory store), src_a = ra, src_b = rb and both destinations are 15. For icode 0x7 (jump) and every icode not listed in R1 to R5, all four IDs are 15. None of these writes a register.
- R6: val_a and val_b show the current contents of registers src_a and src_b in the same cycle, and show zero when the ID is 15.
- R7: On a rising edge with rst low, register dst_e takes val_e and register dst_m takes val_m. A port whose ID is 15 writes nothing.
- R8: When dst_e and dst_m name the same register on one edge, that register takes val_m.
- R9: While rst is high, all fifteen registers are cleared to zero at each rising edge and no write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, clears all registers |
| icode | input | 4 | Instruction code of the current instruction |
| ra | input | 4 | First register field |
| rb | input | 4 | Second register field |
| cnd | input | 1 | Condition result from execute; used by conditional move |
| val_e | input | 64 | ALU result to commit through dst_e |
| val_m | input | 64 | Memory result to commit through dst_m |
| src_a | output | 4 | Read-port A register ID |
| src_b | output | 4 | Read-port B register ID |
| dst_e | output | 4 | Write-port E register ID |
| dst_m | output | 4 | Write-port M register ID |
| val_a | output | 64 | Contents of register src_a, or zero |
| val_b | output | 64 | Contents of register src_b, or zero |

## Verification
The properties assume that icode, ra, rb and cnd carry known values at every sampled edge and stay stable between edges. The write-read property also assumes that the instruction in the following cycle is one of the decoded forms, so that val_a comes from a real read. The bench changes every input only on the falling clock edge, never drives X or Z after time zero, and keeps rst high while it sweeps the decode table. This keeps those sweeps from committing writes that the later directed checks do not expect.

// File: rtl/regid_pkg.sv
package regid_pkg;
  localparam int ID_W    = 4;
  localparam int NUM_IDS = 1 << ID_W;
  localparam logic [ID_W-1:0] ID_NONE = '1;
  localparam logic [ID_W-1:0] ID_STK  = 4'd4;

  // instruction codes decoded by this slice
  localparam logic [3:0] IC_CMOV  = 4'h2;
  localparam logic [3:0] IC_STORE = 4'h4;
  localparam logic [3:0] IC_ALU   = 4'h6;
  localparam logic [3:0] IC_JUMP  = 4'h7;
  localparam logic [3:0] IC_CALL  = 4'h8;
  localparam logic [3:0] IC_RET   = 4'h9;
  localparam logic [3:0] IC_POP   = 4'hB;

  typedef struct packed {
    logic [ID_W-1:0] rd_a;
    logic [ID_W-1:0] rd_b;
    logic [ID_W-1:0] wr_e;
    logic [ID_W-1:0] wr_m;
  } port_ids_t;
endpackage

// File: rtl/regid_select.sv
module regid_select
  import regid_pkg::*;
(
  input  logic [3:0]      icode,
  input  logic [ID_W-1:0] ra,
  input  logic [ID_W-1:0] rb,
  input  logic            cnd,
  output port_ids_t       ids
);
  always_comb begin
    ids = '{rd_a: ID_NONE, rd_b: ID_NONE, wr_e: ID_NONE, wr_m: ID_NONE};
    unique case (icode)
      IC_ALU: begin
        ids.rd_a = ra;
        ids.rd_b = rb;
        ids.wr_e = rb;
      end
      IC_CMOV: begin
        ids.rd_a = ra;
        ids.wr_e = cnd ? rb : ID_NONE;
      end
      IC_STORE: begin
        ids.rd_a = ra;
        ids.rd_b = rb;
      end
      IC_POP: begin
        ids.rd_a = ID_STK;
        ids.rd_b = ID_STK;
        ids.wr_e = ID_STK;
        ids.wr_m = ra;
      end
      IC_RET: begin
        ids.rd_a = ID_STK;
        ids.rd_b = ID_STK;
        ids.wr_e = ID_STK;
      end
      IC_CALL: begin
        ids.rd_b = ID_STK;
        ids.wr_e = ID_STK;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/regfile_dual.sv
module regfile_dual
  import regid_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ID_W-1:0] rd_a,
  input  logic [ID_W-1:0] rd_b,
  input  logic [ID_W-1:0] wr_e,
  input  logic [ID_W-1:0] wr_m,
  input  logic [XLEN-1:0] data_e,
  input  logic [XLEN-1:0] data_m,
  output logic [XLEN-1:0] out_a,
  output logic [XLEN-1:0] out_b
);
  localparam int NREG = NUM_IDS - 1;  // top code is "none"

  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                         regs[g] <= '0;
      else if (wr_m == ID_W'(g))       regs[g] <= data_m;  // M port wins
      else if (wr_e == ID_W'(g))       regs[g] <= data_e;
    end
  end

  always_comb begin
    out_a = '0;
    out_b = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_a == ID_W'(i)) out_a = regs[i];
      if (rd_b == ID_W'(i)) out_b = regs[i];
    end
  end
endmodule

// File: rtl/regid_decode_wb.sv
module regid_decode_wb
  import regid_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      icode,
  input  logic [ID_W-1:0] ra,
  input  logic [ID_W-1:0] rb,
  input  logic            cnd,
  input  logic [XLEN-1:0] val_e,
  input  logic [XLEN-1:0] val_m,
  output logic [ID_W-1:0] src_a,
  output logic [ID_W-1:0] src_b,
  output logic [ID_W-1:0] dst_e,
  output logic [ID_W-1:0] dst_m,
  output logic [XLEN-1:0] val_a,
  output logic [XLEN-1:0] val_b
);
  port_ids_t ids;

  regid_select u_sel (
    .icode (icode),
    .ra    (ra),
    .rb    (rb),
    .cnd   (cnd),
    .ids   (ids)
  );

  assign src_a = ids.rd_a;
  assign src_b = ids.rd_b;
  assign dst_e = ids.wr_e;
  assign dst_m = ids.wr_m;

  regfile_dual #(.XLEN(XLEN)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .rd_a   (ids.rd_a),
    .rd_b   (ids.rd_b),
    .wr_e   (ids.wr_e),
    .wr_m   (ids.wr_m),
    .data_e (val_e),
    .data_m (val_m),
    .out_a  (val_a),
    .out_b  (val_b)
  );
endmodule

// File: rtl/regid_chk.sv
module regid_chk
  import regid_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic [3:0]      icode,
  input logic [ID_W-1:0] ra,
  input logic            cnd,
  input logic [ID_W-1:0] src_a,
  input logic [ID_W-1:0] src_b,
  input logic [ID_W-1:0] dst_e,
  input logic [ID_W-1:0] dst_m,
  input logic [XLEN-1:0] val_a,
  input logic [XLEN-1:0] val_m
);
  assert_pop_ids_R2: assert property (@(posedge clk) disable iff (rst)
    (icode == IC_POP) |-> (src_a == ID_STK && src_b == ID_STK &&
                           dst_e == ID_STK && dst_m == ra));

  assert_cmov_cancel_R4: assert property (@(posedge clk) disable iff (rst)
    (icode == IC_CMOV && !cnd) |-> (dst_e == ID_NONE && dst_m == ID_NONE));

  assert_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (icode == IC_STORE || icode == IC_JUMP) |-> (dst_e == ID_NONE && dst_m == ID_NONE));

  assert_none_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (src_a == ID_NONE) |-> (val_a == '0));

  // M-port value must be visible next cycle (also covers M-over-E priority)
  assert_m_commit_R8: assert property (@(posedge clk) disable iff (rst)
    (dst_m != ID_NONE) |=> (src_a != $past(dst_m) || val_a == $past(val_m)));
endmodule

bind regid_decode_wb regid_chk #(.XLEN(XLEN)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .icode (icode),
  .ra    (ra),
  .cnd   (cnd),
  .src_a (src_a),
  .src_b (src_b),
  .dst_e (dst_e),
  .dst_m (dst_m),
  .val_a (val_a),
  .val_m (val_m)
);

// File: tb/sim_regid_decode_wb.sv
`timescale 1ns/1ps
module sim_regid_decode_wb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  icode = 4'h0, ra = 4'hF, rb = 4'hF;
  logic        cnd = 1'b0;
  logic [63:0] val_e = '0, val_m = '0;
  logic [3:0]  src_a, src_b, dst_e, dst_m;
  logic [63:0] val_a, val_b;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  regid_decode_wb u0 (
    .clk(clk), .rst(rst), .icode(icode), .ra(ra), .rb(rb), .cnd(cnd),
    .val_e(val_e), .val_m(val_m), .src_a(src_a), .src_b(src_b),
    .dst_e(dst_e), .dst_m(dst_m), .val_a(val_a), .val_b(val_b)
  );

  // {icode, ra, rb, cnd, exp src_a, exp src_b, exp dst_e, exp dst_m}
  localparam logic [31:0] VEC [12] = '{
    32'h6120_122F, 32'h6700_700F, 32'hB3F0_4443, 32'hB4F0_4444,
    32'h9FF0_444F, 32'h8FF0_F44F, 32'h2561_5F6F, 32'h2560_5FFF,
    32'h4890_89FF, 32'h7001_FFFF, 32'h0120_FFFF, 32'h3F20_FFFF
  };

  function automatic string tag_of(input logic [3:0] ic);
    case (ic)
      4'h6: return "R1";
      4'hB: return "R2";
      4'h9, 4'h8: return "R3";
      4'h2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] ic, input logic [3:0] a, input logic [3:0] b,
                       input logic c, input logic [63:0] ve, input logic [63:0] vm);
    @(negedge clk);
    icode = ic; ra = a; rb = b; cnd = c; val_e = ve; val_m = vm;
  endtask

  task automatic commit(input logic [3:0] ic, input logic [3:0] a, input logic [3:0] b,
                        input logic c, input logic [63:0] ve, input logic [63:0] vm);
    drive(ic, a, b, c, ve, vm);
    @(posedge clk);
  endtask

  // read two registers through the store form (no write side effect)
  task automatic rd(input string tag, input logic [3:0] a, input logic [3:0] b,
                    input logic [63:0] ea, input logic [63:0] eb);
    drive(4'h4, a, b, 1'b0, 64'hDEAD, 64'hBEEF);
    #5;
    chk(tag, val_a, ea);
    chk(tag, val_b, eb);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // decode table sweep, held in reset so nothing commits
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      {icode, ra, rb} = VEC[i][31:20];
      cnd = VEC[i][16];
      #5;
      chk(tag_of(icode), {48'd0, src_a, src_b, dst_e, dst_m}, {48'd0, VEC[i][15:0]});
    end
    // R9: reset state
    drive(4'h1, 4'hF, 4'hF, 1'b0, '0, '0);
    @(posedge clk);
    @(negedge clk); rst = 1'b0;
    for (int r = 0; r < 14; r += 2) rd("R9", r[3:0], 4'(r + 1), '0, '0);
    rd("R6", 4'd14, 4'hF, '0, '0);
    // R1/R7: ALU write to rb
    commit(4'h6, 4'd1, 4'd2, 1'b0, 64'hA5A5_0000_0000_0002, 64'h77);
    rd("R7", 4'd2, 4'd1, 64'hA5A5_0000_0000_0002, '0);
    rd("R6", 4'hF, 4'd2, '0, 64'hA5A5_0000_0000_0002);
    // R2: pop writes both ports
    commit(4'hB, 4'd3, 4'hF, 1'b0, 64'd100, 64'd200);
    rd("R2", 4'd4, 4'd3, 64'd100, 64'd200);
    // R8: pop into the stack pointer, M wins
    commit(4'hB, 4'd4, 4'hF, 1'b0, 64'd111, 64'd222);
    rd("R8", 4'd4, 4'd3, 64'd222, 64'd200);
    // R4: failed conditional move leaves rb alone, then a taken one
    commit(4'h2, 4'd5, 4'd6, 1'b0, 64'd555, 64'd9);
    rd("R4", 4'd6, 4'd5, '0, '0);
    commit(4'h2, 4'd5, 4'd6, 1'b1, 64'd555, 64'd9);
    rd("R4", 4'd6, 4'd5, 64'd555, '0);
    // R5: store and jump write nothing
    commit(4'h4, 4'd1, 4'd2, 1'b0, 64'd999, 64'd888);
    commit(4'h7, 4'd2, 4'd3, 1'b1, 64'd999, 64'd888);
    rd("R5", 4'd2, 4'd3, 64'hA5A5_0000_0000_0002, 64'd200);
    // R3: call updates the stack pointer only
    commit(4'h8, 4'hF, 4'hF, 1'b0, 64'h40, 64'h50);
    rd("R3", 4'd4, 4'd3, 64'h40, 64'd200);
    commit(4'h9, 4'hF, 4'hF, 1'b0, 64'h48, 64'h60);
    rd("R3", 4'd4, 4'd14, 64'h48, '0);
    // R7: ID 15 on both ports writes nothing
    commit(4'h1, 4'hF, 4'hF, 1'b0, 64'h1, 64'h2);
    rd("R7", 4'd4, 4'd6, 64'h48, 64'd555);
    // R9: reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    @(negedge clk); rst = 1'b0;
    rd("R9", 4'd2, 4'd3, '0, '0);
    rd("R9", 4'd4, 4'd6, '0, '0);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule